// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Controller

This block keeps an asynchronous DRAM's contents alive and brings the device up after reset. Out of reset it counts out a fixed power-up pause. It then runs a short burst of refresh cycles in which CAS falls before RAS. When the last of those cycles has finished its precharge, it declares the memory usable. After that an interval timer raises one refresh obligation per fixed period, so that every row is refreshed within the retention window. The device's own row counter picks the row, so no address is driven.

For each refresh the block asks the access sequencer for the bus. Once it is granted, the block drives the strobes itself: CAS low, then RAS low, then CAS released, then RAS released, then a precharge gap. The write strobe stays high throughout. Obligations that cannot be served at once are counted. When the count reaches its limit, an urgency flag tells the sequencer to put refresh ahead of host traffic. All durations are given in nanoseconds and converted to whole clock cycles, rounding up.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: While reset is asserted, init_done, bus_own and ref_req are low, and dram_ras_n, dram_cas_n and dram_we_n are high.
- R2: After reset is released, ref_req stays low for PAUSE_CYC clock edges. It is high after edge number PAUSE_CYC.
- R3: Exactly INIT_REFRESHES granted refresh cycles are run after the pause. init_done rises on the edge that ends the precharge of the last of them, and then stays high until reset.
- R4: A refresh cycle starts on the edge where ref_req and ref_gnt are both high. dram_cas_n then goes low while dram_ras_n stays high for CSR_CYC cycles (2 with defaults at 4 ns).
- R5: dram_ras_n falls while dram_cas_n is low. dram_cas_n stays low for CHR_CYC cycles (2) and then rises while dram_ras_n is still low.
- R6: dram_ras_n stays low for RAS_CYC cycles (16), then both strobes stay high for PRE_CYC cycles (10) with bus_own still high. bus_own falls after that, 28 cycles after the start in total.
- R7: dram_we_n is high at all times.
- R8: Without a grant the strobes stay high and bus_own stays low, even while a request is pending.
- R9: Once init_done is high, one refresh obligation is added every INT_CYC cycles (first on edge INT_CYC after init_done rises). ref_req is high whenever an obligation is outstanding and no cycle is running.
- R10: At most MAX_PEND obligations are held; further ticks are dropped. ref_urgent is high exactly when the count equals MAX_PEND. Each completed cycle removes one.
- R11: ref_req is low whenever bus_own is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer, sampled only while requesting |
| ref_req | output | 1 | Bus request for one refresh cycle |
| ref_urgent | output | 1 | Backlog at its limit; refresh must win arbitration |
| bus_own | output | 1 | Block is driving the DRAM strobes |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Memory initialised and usable |

## Verification
The properties assume that the sequencer only grants while ref_req is high and does not drive the strobes while bus_own is high. They also assume that reset is held low from time zero. The bench always raises ref_gnt for a single cycle, and only after it has seen ref_req high at a falling edge. It withholds the grant for long stretches to build up the backlog, and it asserts reset in the middle of a cycle only from the falling edge.

// File: rtl/cbr_ref_pkg.sv
package cbr_ref_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE,
    MODE_BURST,
    MODE_RUN
  } init_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD,
    PH_RASLO,
    PH_PRECH
  } ref_phase_e;

  // whole cycles covering a duration, never below one
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold values 0..n
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cbr_period_timer.sv
module cbr_period_timer #(
  parameter int N = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = cbr_ref_pkg::width_for(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbr_backlog_ctr.sv
module cbr_backlog_ctr #(
  parameter int MAX_PEND = 4,
  parameter int PEND_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] count,
  output logic              at_limit,
  output logic              nonzero
);
  localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_PEND);

  logic [PEND_W-1:0] cnt_q;
  logic              inc_ok;
  logic              dec_ok;

  assign inc_ok   = inc && ((cnt_q != LIMIT) || dec);
  assign dec_ok   = dec && (cnt_q != '0);
  assign count    = cnt_q;
  assign at_limit = (cnt_q == LIMIT);
  assign nonzero  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_ok && !dec_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_ok && !inc_ok) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_ref_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 16,
  parameter int PRE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  localparam int LONGEST = max_of(max_of(CSR_CYC, CHR_CYC),
                                  max_of(RAS_CYC - CHR_CYC, PRE_CYC));
  localparam int CW = width_for(LONGEST);
  localparam logic [CW-1:0] LEN_SETUP = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] LEN_HOLD  = CW'(CHR_CYC - 1);
  localparam logic [CW-1:0] LEN_RASLO = CW'(RAS_CYC - CHR_CYC - 1);
  localparam logic [CW-1:0] LEN_PRECH = CW'(PRE_CYC - 1);

  ref_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == '0);
  assign cas_n = !((phase_q == PH_SETUP) || (phase_q == PH_HOLD));
  assign ras_n = !((phase_q == PH_HOLD) || (phase_q == PH_RASLO));
  assign busy  = (phase_q != PH_IDLE);
  assign done  = (phase_q == PH_PRECH) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETUP;
            cnt_q   <= LEN_SETUP;
          end
        end
        PH_SETUP: begin
          if (last) begin
            phase_q <= PH_HOLD;
            cnt_q   <= LEN_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (last) begin
            phase_q <= PH_RASLO;
            cnt_q   <= LEN_RASLO;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RASLO: begin
          if (last) begin
            phase_q <= PH_PRECH;
            cnt_q   <= LEN_PRECH;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PRECH: begin
          if (last) begin
            phase_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_ref_pkg::*;
#(
  parameter int CLK_NS         = 4,
  parameter int PAUSE_NS       = 200000,
  parameter int INTERVAL_NS    = 15600,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_PEND       = 4,
  parameter int CSR_NS         = 5,
  parameter int CHR_NS         = 8,
  parameter int RAS_NS         = 60,
  parameter int RC_NS          = 104,
  parameter int PRE_NS         = 40,
  parameter int RPC_NS         = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n,
  output logic init_done
);
  localparam int PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_NS);
  localparam int INT_CYC   = ns_to_cycles(INTERVAL_NS, CLK_NS);
  localparam int CSR_CYC   = ns_to_cycles(CSR_NS, CLK_NS);
  localparam int CHR_CYC   = ns_to_cycles(CHR_NS, CLK_NS);
  localparam int PRE_CYC   = max_of(ns_to_cycles(PRE_NS, CLK_NS),
                                    ns_to_cycles(RPC_NS, CLK_NS));
  localparam int RAS_CYC   = max_of(max_of(ns_to_cycles(RAS_NS, CLK_NS),
                                           ns_to_cycles(RC_NS, CLK_NS) - PRE_CYC),
                                    CHR_CYC + 1);
  localparam int PEND_W    = width_for(MAX_PEND);
  localparam int BURST_W   = width_for(INIT_REFRESHES);
  localparam logic [BURST_W-1:0] BURST_LOAD = BURST_W'(INIT_REFRESHES);

  init_mode_e         mode_q;
  logic [BURST_W-1:0] burst_left_q;

  // named internal events
  logic              pause_over;
  logic              period_tick;
  logic              cyc_start;
  logic              cyc_done;
  logic              seq_busy;
  logic              backlog_full;
  logic              backlog_any;
  logic [PEND_W-1:0] pend_cnt;
  logic              run_mode;
  logic              last_burst_done;

  assign run_mode        = (mode_q == MODE_RUN);
  assign cyc_start       = ref_req && ref_gnt;
  assign last_burst_done = (mode_q == MODE_BURST) && cyc_done &&
                           (burst_left_q == BURST_W'(1));

  cbr_period_timer #(.N(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (mode_q == MODE_PAUSE),
    .tick (pause_over)
  );

  cbr_period_timer #(.N(INT_CYC)) u_period (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run_mode),
    .tick (period_tick)
  );

  cbr_backlog_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (period_tick),
    .dec     (run_mode && cyc_done),
    .count   (pend_cnt),
    .at_limit(backlog_full),
    .nonzero (backlog_any)
  );

  cbr_strobe_seq #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cyc_start),
    .ras_n(dram_ras_n),
    .cas_n(dram_cas_n),
    .busy (seq_busy),
    .done (cyc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_PAUSE;
      burst_left_q <= BURST_LOAD;
    end else begin
      unique case (mode_q)
        MODE_PAUSE: if (pause_over) mode_q <= MODE_BURST;
        MODE_BURST: begin
          if (last_burst_done) begin
            mode_q <= MODE_RUN;
          end else if (cyc_done) begin
            burst_left_q <= burst_left_q - 1'b1;
          end
        end
        MODE_RUN: mode_q <= MODE_RUN;
        default:  mode_q <= MODE_PAUSE;
      endcase
    end
  end

  assign ref_req    = !seq_busy &&
                      ((mode_q == MODE_BURST) || (run_mode && backlog_any));
  assign ref_urgent = backlog_full;
  assign bus_own    = seq_busy;
  assign dram_we_n  = 1'b1;
  assign init_done  = run_mode;
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
  parameter int RAS_CYC  = 16,
  parameter int MAX_PEND = 4,
  parameter int PEND_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_gnt,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic              bus_own,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              init_done,
  input logic [PEND_W-1:0] pend_cnt,
  input logic              cyc_done
);
  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_lo_cnt <= '0;
    else if (!dram_ras_n) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    else ras_lo_cnt <= '0;
  end

  // R8
  cas_fall_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $past(ref_req && ref_gnt));

  // R4
  ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (!dram_cas_n && $past(!dram_cas_n)));

  // R5
  cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_lo_cnt == 16'(RAS_CYC)));

  // R6
  release_precharged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own) |-> ($past(dram_ras_n) && $past(dram_cas_n)));

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3
  ready_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cyc_done));

  // R10
  backlog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PEND_W'(MAX_PEND));

  // R10
  urgent_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || bus_own));

  // R11
  no_req_while_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> !ref_req);
endmodule

bind cbr_refresh_ctrl cbr_refresh_chk #(
  .RAS_CYC (RAS_CYC),
  .MAX_PEND(MAX_PEND),
  .PEND_W  (PEND_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .bus_own   (bus_own),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .init_done (init_done),
  .pend_cnt  (pend_cnt),
  .cyc_done  (cyc_done)
);

// File: tb/cbr_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module cbr_refresh_ctrl_bench;
  // bench constants restated from the requirements at 4 ns
  localparam int PAUSE_C = 100;  // 400 ns
  localparam int INT_C   = 200;  // 800 ns
  localparam int BURST_N = 8;
  localparam int MAXP    = 3;

  // {offset[5:0], ras_n, cas_n, bus_own} from the start edge
  localparam logic [8:0] SHAPE [9] = '{
    {6'd0,  3'b101},  // R4 setup
    {6'd1,  3'b101},  // R4 setup
    {6'd2,  3'b001},  // R5 hold
    {6'd3,  3'b001},  // R5 hold
    {6'd4,  3'b011},  // R5 cas released
    {6'd17, 3'b011},  // R6 ras still low
    {6'd18, 3'b111},  // R6 precharge
    {6'd27, 3'b111},  // R6 precharge end
    {6'd28, 3'b110}   // R6 released
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, bus_own, dram_ras_n, dram_cas_n, dram_we_n, init_done;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cbr_refresh_ctrl #(
    .PAUSE_NS(400), .INTERVAL_NS(800), .INIT_REFRESHES(BURST_N), .MAX_PEND(MAXP)
  ) u_cbr_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .bus_own(bus_own), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .init_done(init_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // grant one cycle and walk the expected strobe shape; ends at offset 28
  task automatic walk(output logic ready_at27);
    int pos = 0;
    ready_at27 = 1'b0;
    chk("R9 req before grant", int'(ref_req), 1);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk("R11 req while owning", int'(ref_req), 0);
    for (int i = 0; i < 9; i++) begin
      while (pos < int'(SHAPE[i][8:3])) begin
        @(negedge clk);
        pos++;
        if (pos == 27) ready_at27 = init_done;
      end
      chk("R4/R5/R6 strobes", int'({dram_ras_n, dram_cas_n, bus_own}), int'(SHAPE[i][2:0]));
      chk("R7 we_n", int'(dram_we_n), 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic r27;
    int served;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 init_done", int'(init_done), 0);
    chk("R1 bus_own", int'(bus_own), 0);
    chk("R1 ref_req", int'(ref_req), 0);
    chk("R1 strobes", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    rst_n = 1'b1;

    // R2 pause length
    repeat (PAUSE_C - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 req before pause end", int'(ref_req), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 req at pause end", int'(ref_req), 1);

    // R8 nothing happens without a grant
    repeat (5) @(negedge clk);
    chk("R8 cas idle", int'(dram_cas_n), 1);
    chk("R8 ras idle", int'(dram_ras_n), 1);
    chk("R8 not owned", int'(bus_own), 0);

    // R3 initial burst
    for (int b = 0; b < BURST_N; b++) begin
      walk(r27);
      chk("R3 ready at offset 27", int'(r27), 0);
      chk("R3 ready at offset 28", int'(init_done), (b == BURST_N - 1) ? 1 : 0);
      if (b < BURST_N - 1) chk("R3 re-request", int'(ref_req), 1);
    end

    // R9 first obligation after INT_C edges
    repeat (INT_C - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 no req before tick", int'(ref_req), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 req after tick", int'(ref_req), 1);
    chk("R10 not urgent at one", int'(ref_urgent), 0);

    // R10 backlog reaches its limit on the third tick
    repeat (2 * INT_C - 1) @(posedge clk);
    @(negedge clk);
    chk("R10 urgent before third", int'(ref_urgent), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 urgent at limit", int'(ref_urgent), 1);

    // fourth tick is dropped
    repeat (INT_C + 5) @(negedge clk);
    chk("R10 still urgent", int'(ref_urgent), 1);
    served = 0;
    while (ref_req && served < 10) begin
      walk(r27);
      served++;
      if (served == 1) chk("R10 urgent clears", int'(ref_urgent), 0);
    end
    chk("R10 served equals limit", served, MAXP);
    chk("R9 req idle when empty", int'(ref_req), 0);

    // R1 reset in the middle of a cycle
    while (!ref_req) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-cycle strobes", int'({dram_ras_n, dram_cas_n}), 3);
    chk("R1 mid-cycle own", int'(bus_own), 0);
    chk("R1 mid-cycle ready", int'(init_done), 0);
    chk("R1 mid-cycle req", int'(ref_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk("R2 pause restarts", int'(ref_req), 0);
    chk("R3 not ready again", int'(init_done), 0);
    summary();
  end
endmodule